// File: doc/BRIEF.md
# Open-Load Test Sequencer with Grey-Clock Loss Guard

This block runs the open-load test of a sixteen-channel LED current-sink driver. A single-cycle start command overrides the normal PWM drive and turns every channel on. The block holds them on for a fixed number of system-clock cycles so that the sink voltages can settle. In the last of those cycles it samples one comparator bit per channel into a status register, and a serial read-out path can shift that register out. When the window ends, PWM drive resumes. A start command that arrives while a test is running restarts the window.

The same block watches the grey-scale clock. The clock arrives asynchronously. It is synchronised into the system-clock domain, and either of its edges counts as activity. When the guard is enabled and no activity is seen for a programmable number of cycles, the block raises a kill flag that turns all outputs off. When activity returns, the flag drops. In that same cycle the block sends a one-cycle pulse that tells the PWM counters and comparators to restart from zero.

Top module: `open_load_seq`

## Requirements
- R1: After a synchronous reset, `force_mask` and `status` are all zeros, and `out_off` and `pwm_rst` are 0.
- R2: When `det_cmd` is sampled high, `force_mask` becomes all ones from the next cycle. It stays all ones for exactly `SETTLE` cycles and then returns to all zeros. It is never partly set.
- R3: On the last forced cycle, `status` captures `load_ok` as it is presented in that cycle. The new value is visible from the following cycle. Bit i is 1 for a normal load on channel i and 0 for an open load.
- R4: `status` changes only in the cycle right after a forced window ends. Changes on `load_ok` at any other time have no effect on it.
- R5: A `det_cmd` that arrives during a forced window restarts the window. `force_mask` then stays all ones for `SETTLE` cycles counted from that command.
- R6: With `wdog_dis` = 0, `out_off` rises once `TIMEOUT` consecutive cycles have passed without a recognised grey-clock edge. A test can still be run and captured while `out_off` is high.
- R7: With `wdog_dis` = 1, `out_off` is 0 from the next cycle on, and the idle count is held at zero. Re-enabling the guard starts a full new `TIMEOUT` interval.
- R8: While `out_off` is high, a recognised grey-clock edge clears `out_off` and raises `pwm_rst` for exactly one cycle, in the same cycle. `pwm_rst` is never high at any other time.
- R9: A rising or a falling level change on `gclk_in` is recognised as activity two system clocks after it is sampled, and it restarts the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| det_cmd | input | 1 | Start (or restart) an open-load test |
| gclk_in | input | 1 | Grey-scale clock, asynchronous to `clk` |
| load_ok | input | N_CH | Per-channel comparator: 1 normal, 0 open |
| wdog_dis | input | 1 | 1 turns the clock-loss guard off |
| force_mask | output | N_CH | All ones while channels are forced on |
| status | output | N_CH | Captured open-load result |
| out_off | output | 1 | Clock-loss kill: all outputs off |
| pwm_rst | output | 1 | One-cycle restart pulse for PWM counters |

## Verification
The hardest behaviour to reach from the ports is the idle count being pushed back by a single lone edge just before it would expire. The stimulus stops the grey clock, waits until the guard is a few cycles from tripping, and then flips `gclk_in` exactly once. This shows that the two-cycle synchroniser delay and the count restart line up. The bench also changes `load_ok` on the exact final forced cycle, which tells a correct capture apart from one that is a cycle early or a cycle late. It also runs a test while the kill flag is set.

// File: rtl/ols_pkg.sv
package ols_pkg;
  typedef enum logic {DET_IDLE, DET_FORCE} det_state_e;

  function automatic int cw(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ols_gclk_sync.sv
module ols_gclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic activity
);
  // STAGES synchroniser flops plus one history flop for edge compare
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign activity = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/ols_detect.sv
module ols_detect #(
  parameter int N_CH   = 16,
  parameter int SETTLE = 200
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [N_CH-1:0] load_ok,
  output logic            forcing,
  output logic [N_CH-1:0] status
);
  import ols_pkg::*;
  localparam int CW = cw(SETTLE);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  det_state_e      st;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= DET_IDLE;
      cnt    <= '0;
      status <= '0;
    end else if (start) begin
      st  <= DET_FORCE;
      cnt <= LAST;
    end else if (st == DET_FORCE) begin
      if (cnt == '0) begin
        st     <= DET_IDLE;
        status <= load_ok;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign forcing = (st == DET_FORCE);
endmodule

// File: rtl/ols_watchdog.sv
module ols_watchdog #(
  parameter int TIMEOUT = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic activity,
  output logic tripped,
  output logic restart
);
  import ols_pkg::*;
  localparam int WW = cw(TIMEOUT);
  localparam logic [WW-1:0] LIMIT = WW'(TIMEOUT - 1);

  logic [WW-1:0] idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle    <= '0;
      tripped <= 1'b0;
      restart <= 1'b0;
    end else begin
      restart <= 1'b0;
      if (!enable) begin
        idle    <= '0;
        tripped <= 1'b0;
      end else if (activity) begin
        idle <= '0;
        if (tripped) begin
          tripped <= 1'b0;
          restart <= 1'b1;
        end
      end else if (idle == LIMIT) begin
        tripped <= 1'b1;
      end else begin
        idle <= idle + 1'b1;
      end
    end
  end
endmodule

// File: rtl/open_load_seq.sv
module open_load_seq #(
  parameter int N_CH     = 16,
  parameter int SETTLE   = 200,
  parameter int TIMEOUT  = 100_000_000,
  parameter int SYNC_STG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            det_cmd,
  input  logic            gclk_in,
  input  logic [N_CH-1:0] load_ok,
  input  logic            wdog_dis,
  output logic [N_CH-1:0] force_mask,
  output logic [N_CH-1:0] status,
  output logic            out_off,
  output logic            pwm_rst
);
  logic forcing;
  logic activity;

  ols_gclk_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_in(gclk_in), .activity(activity)
  );

  ols_detect #(.N_CH(N_CH), .SETTLE(SETTLE)) u_det (
    .clk(clk), .rst(rst), .start(det_cmd), .load_ok(load_ok),
    .forcing(forcing), .status(status)
  );

  ols_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
    .clk(clk), .rst(rst), .enable(!wdog_dis), .activity(activity),
    .tripped(out_off), .restart(pwm_rst)
  );

  // fan the registered forcing state out to every channel
  for (genvar i = 0; i < N_CH; i++) begin : g_force
    assign force_mask[i] = forcing;
  end
endmodule

// File: rtl/ols_checker.sv
module ols_checker #(
  parameter int N_CH = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            det_cmd,
  input logic            wdog_dis,
  input logic [N_CH-1:0] force_mask,
  input logic [N_CH-1:0] status,
  input logic            out_off,
  input logic            pwm_rst
);
  a_r2_all_or_none: assert property (@(posedge clk) disable iff (rst)
    (force_mask == '0) || (force_mask == '1));

  a_r2_cmd_forces: assert property (@(posedge clk) disable iff (rst)
    det_cmd |=> (force_mask == '1));

  a_r4_status_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> $fell(force_mask[0]));

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    wdog_dis |=> !out_off);

  a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
    pwm_rst |=> !pwm_rst);

  a_r8_pulse_on_recover: assert property (@(posedge clk) disable iff (rst)
    pwm_rst |-> $fell(out_off));
endmodule

bind open_load_seq ols_checker #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .det_cmd(det_cmd), .wdog_dis(wdog_dis),
  .force_mask(force_mask), .status(status), .out_off(out_off),
  .pwm_rst(pwm_rst)
);

// File: tb/open_load_seq_test.sv
module open_load_seq_test;
  localparam int N  = 16;
  localparam int S  = 8;
  localparam int TO = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         det_cmd = 1'b0;
  logic         gclk_in = 1'b0;
  logic [N-1:0] load_ok = '1;
  logic         wdog_dis = 1'b0;
  logic [N-1:0] force_mask, status;
  logic         out_off, pwm_rst;

  int errors = 0;
  int checks = 0;

  open_load_seq #(.N_CH(N), .SETTLE(S), .TIMEOUT(TO)) uut (
    .clk(clk), .rst(rst), .det_cmd(det_cmd), .gclk_in(gclk_in),
    .load_ok(load_ok), .wdog_dis(wdog_dis), .force_mask(force_mask),
    .status(status), .out_off(out_off), .pwm_rst(pwm_rst)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  bit           m_busy, m_trip, m_prst;
  int           m_left, m_idle;
  logic [N-1:0] m_stat;
  bit           seen[$];   // recent gclk samples, newest first
  bit           gclk_run = 0;
  int           gdiv = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit act;
    if (rst) begin
      m_busy = 0; m_left = 0; m_stat = '0;
      m_idle = 0; m_trip = 0; m_prst = 0;
      seen = '{0, 0, 0};
      return;
    end
    // activity seen once a level change reaches the older two samples
    act = (seen[1] != seen[2]);
    seen.push_front(gclk_in);
    void'(seen.pop_back());
    if (det_cmd) begin
      m_busy = 1; m_left = S - 1;
    end else if (m_busy) begin
      if (m_left == 0) begin m_busy = 0; m_stat = load_ok; end
      else m_left--;
    end
    m_prst = 0;
    if (wdog_dis) begin
      m_idle = 0; m_trip = 0;
    end else if (act) begin
      m_idle = 0;
      if (m_trip) begin m_trip = 0; m_prst = 1; end
    end else if (m_idle == TO - 1) begin
      m_trip = 1;
    end else begin
      m_idle++;
    end
  endtask

  task automatic tick();
    if (gclk_run) begin
      gdiv++;
      if (gdiv == 3) begin gdiv = 0; gclk_in = ~gclk_in; end
    end
    model_step();
    @(negedge clk);
    check(force_mask == (m_busy ? {N{1'b1}} : {N{1'b0}}), "R2 force_mask",
          32'(force_mask), m_busy ? 32'hFFFF : 32'h0);
    check(status == m_stat, "R3 status", 32'(status), 32'(m_stat));
    check(out_off == m_trip, "R6 out_off", 32'(out_off), 32'(m_trip));
    check(pwm_rst == m_prst, "R8 pwm_rst", 32'(pwm_rst), 32'(m_prst));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic run_test(input logic [N-1:0] pat);
    load_ok = pat; det_cmd = 1'b1; tick(); det_cmd = 1'b0;
    ticks(S + 2);
    check(status == pat, "R3 capture", 32'(status), 32'(pat));
  endtask

  initial begin
    seen = '{0, 0, 0};
    ticks(3);
    rst = 1'b0;
    tick();
    check(force_mask == '0 && status == '0 && !out_off && !pwm_rst, "R1 reset",
          {force_mask, status}, 32'h0);
    gclk_run = 1;
    ticks(10);

    // R3: the value on the final forced cycle is the one kept
    load_ok = 16'hA5C3; det_cmd = 1'b1; tick(); det_cmd = 1'b0;
    ticks(S - 1);
    load_ok = 16'h7E18; tick();
    load_ok = 16'h0001; ticks(3);
    check(status == 16'h7E18, "R3 last cycle", 32'(status), 32'h7E18);

    // R4: inputs outside a window are ignored
    load_ok = 16'hFFFF; ticks(10);
    check(status == 16'h7E18, "R4 hold", 32'(status), 32'h7E18);

    // R5: restart inside the window
    det_cmd = 1'b1; tick(); det_cmd = 1'b0; ticks(4);
    det_cmd = 1'b1; tick(); det_cmd = 1'b0; ticks(S - 2);
    check(force_mask == '1, "R5 restart", 32'(force_mask), 32'hFFFF);
    ticks(4);

    run_test(16'hFFF6);   // two open channels

    // R6: grey clock lost
    gclk_run = 0; ticks(TO + 20);
    check(out_off == 1'b1, "R6 trip", 32'(out_off), 32'h1);
    run_test(16'h0F0F);   // test still works while killed

    // R8: recovery
    gclk_run = 1; ticks(10);
    check(out_off == 1'b0, "R8 recover", 32'(out_off), 32'h0);

    // R9: a lone edge just before expiry pushes the trip out
    gclk_run = 0; ticks(TO - 10);
    gclk_in = ~gclk_in; ticks(15);
    check(out_off == 1'b0, "R9 lone edge", 32'(out_off), 32'h0);
    ticks(TO);
    check(out_off == 1'b1, "R9 later trip", 32'(out_off), 32'h1);

    // R7: guard off
    wdog_dis = 1'b1; ticks(TO + 20);
    check(out_off == 1'b0, "R7 disabled", 32'(out_off), 32'h0);
    wdog_dis = 1'b0; ticks(TO + 10);
    check(out_off == 1'b1, "R7 re-enabled", 32'(out_off), 32'h1);
    gclk_run = 1; ticks(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule